// File: doc/BRIEF.md
# Vector Feature-Control Register Unit

This block sits beside the issue stage of a vector pipeline. It handles one architectural register that holds three kinds of information: the predicate that masks an operation, the optional per-operation controls, and the result flags that operations record. Only one bit of each instruction, the feature-enable bit, decides whether the optional controls in that register apply. When this bit is clear, the predicate is still honoured. Every other field then falls back to its default, and the register is left exactly as it was.

Each operation arrives on a valid/ready input stream. The stream carries the feature-enable bit, the current register value, and the condition and error flags that the arithmetic unit produced. The effective controls (active, rounding, exception suppression, zeroing) come out combinationally in the same cycle. One cycle after the operation is accepted, a result beat appears on a valid/ready output stream. The beat holds the register value to write back and a write-enable that says whether a write-back is produced at all. A beat is held unchanged while the consumer stalls, and no new operation is taken while a beat is held (`in_ready` = `!out_valid || out_ready`). A feature-enabled operation with a non-zero reserved bit produces no write-back and raises a one-cycle illegal-feature pulse.

Register layout, which is fixed:
- Bit 0 is active: 1 means the operation runs, 0 means it is masked.
- Bits 2:1 select rounding: 0 nearest (the default), 1 down, 2 up, 3 toward zero.
- Bit 3 suppresses exceptions.
- Bit 4 selects zeroing.
- Bits 8:5 hold the flags C, Z, S, V, with C at bit 5.
- Bits 12:9 hold the sticky errors, with error input bit 0 at bit 9.
- Bits 15:13 are reserved.

Top module: `fpm_ctrl`

## Requirements
- R1: With `in_feat_en`=0, `ctl_round`=0, `ctl_exc_suppress`=0 and `ctl_zeroing`=0, whatever the register bits 4:1 hold.
- R2: With `in_feat_en`=1, `ctl_round` equals bits 2:1, `ctl_exc_suppress` equals bit 3 and `ctl_zeroing` equals bit 4 of `in_fpm`.
- R3: `ctl_active` equals bit 0 of `in_fpm` in both modes.
- R4: With `in_feat_en`=0, the result beat has `out_wr_en`=0 and `out_fpm` equal to the input register value.
- R5: With `in_feat_en`=1, predicate 1 and reserved bits zero, the result beat has `out_wr_en`=1. Its bits 8:5 are replaced by `in_flags[3:0]` and its bits 12:9 become old OR `in_errs`. All other bits are unchanged.
- R6: An error bit already set in the register stays set in `out_fpm` even when the new error input is 0.
- R7: With `in_feat_en`=1 and any of bits 15:13 set, `ill_fault` is high for exactly the one cycle in which the result beat appears, and that beat has `out_wr_en`=0 and the register value unchanged.
- R8: With `in_feat_en`=0, non-zero reserved bits raise no fault.
- R9: With `in_feat_en`=1 and predicate 0, the result beat has `out_wr_en`=0 and the register value unchanged.
- R10: A result beat is valid one cycle after its operation is accepted. `out_valid` drops one cycle after the beat is taken if no new operation is accepted.
- R11: While `out_valid`=1 and `out_ready`=0, the beat stays stable and `in_ready`=0.
- R12: After reset, `out_valid`=0, `ill_fault`=0 and `in_ready`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation present |
| in_ready | output | 1 | Operation can be taken |
| in_feat_en | input | 1 | Feature-enable bit of the instruction |
| in_fpm | input | 16 | Current feature/predicate/flag register |
| in_flags | input | 4 | New C, Z, S, V flags (bit 0 = C) |
| in_errs | input | 4 | New error indications |
| ctl_active | output | 1 | Operation not masked |
| ctl_round | output | 2 | Effective rounding mode |
| ctl_exc_suppress | output | 1 | Effective exception suppression |
| ctl_zeroing | output | 1 | Effective zeroing of masked lanes |
| out_valid | output | 1 | Result beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_wr_en | output | 1 | Beat carries a register write-back |
| out_fpm | output | 16 | Register value for the beat |
| ill_fault | output | 1 | One-cycle illegal-feature pulse |

## Verification
The control outputs are combinational, so the bench samples them one time unit after it drives the inputs, before the accepting edge. The write-back value, write-enable and fault pulse are all due in the cycle after the accepting edge. The bench therefore samples them at the falling edge that follows. Stalls are tested by holding `out_ready` low across several edges and sampling the held beat at each falling edge. The fault pulse is shown to last one cycle by checking that it is low for the vector that follows.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int RND_W    = 2;
  localparam int FLAG_W   = 4;
  localparam int ERR_W    = 4;
  localparam int PRED_POS = 0;
  localparam int RND_LO   = PRED_POS + 1;
  localparam int EXC_POS  = RND_LO + RND_W;
  localparam int ZERO_POS = EXC_POS + 1;
  localparam int FLAG_LO  = ZERO_POS + 1;
  localparam int ERR_LO   = FLAG_LO + FLAG_W;
  localparam int USED_W   = ERR_LO + ERR_W;

  typedef enum logic [RND_W-1:0] {
    RND_NEAR = 2'd0,
    RND_DOWN = 2'd1,
    RND_UP   = 2'd2,
    RND_TRNC = 2'd3
  } rnd_e;

  typedef struct packed {
    logic active;
    rnd_e rnd;
    logic exc_off;
    logic zeroing;
  } op_ctl_t;
endpackage

// File: rtl/fpm_decode.sv
module fpm_decode
  import fpm_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic             feat_en,
  input  logic [REG_W-1:0] fpm,
  output op_ctl_t          ctl,
  output logic             rsv_bad,
  output logic             wb_allow
);
  logic rsv_nz;

  // Any reserved bit above the used fields
  generate
    if (REG_W > USED_W) begin : g_rsv
      assign rsv_nz = |fpm[REG_W-1:USED_W];
    end else begin : g_norsv
      assign rsv_nz = 1'b0;
    end
  endgenerate

  // R1 R2 R3: the predicate always passes; the other fields need feat_en
  always_comb begin
    ctl.active  = fpm[PRED_POS];
    ctl.rnd     = RND_NEAR;
    ctl.exc_off = 1'b0;
    ctl.zeroing = 1'b0;
    if (feat_en) begin
      ctl.rnd     = rnd_e'(fpm[RND_LO +: RND_W]);
      ctl.exc_off = fpm[EXC_POS];
      ctl.zeroing = fpm[ZERO_POS];
    end
  end

  assign rsv_bad  = feat_en & rsv_nz;
  assign wb_allow = feat_en & ~rsv_nz & fpm[PRED_POS];
endmodule

// File: rtl/fpm_merge.sv
module fpm_merge
  import fpm_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic [REG_W-1:0]  fpm,
  input  logic [FLAG_W-1:0] flags,
  input  logic [ERR_W-1:0]  errs,
  output logic [REG_W-1:0]  merged
);
  // R5 R6: the flag field is replaced, the error field accumulates
  generate
    for (genvar i = 0; i < REG_W; i++) begin : g_bit
      if (i >= FLAG_LO && i < ERR_LO) begin : g_flag
        assign merged[i] = flags[i-FLAG_LO];
      end else if (i >= ERR_LO && i < USED_W) begin : g_err
        assign merged[i] = fpm[i] | errs[i-ERR_LO];
      end else begin : g_keep
        assign merged[i] = fpm[i];
      end
    end
  endgenerate
endmodule

// File: rtl/fpm_outstage.sv
module fpm_outstage #(
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             wr_d,
  input  logic [REG_W-1:0] data_d,
  input  logic             fault_d,
  input  logic             out_ready,
  output logic             can_take,
  output logic             out_valid,
  output logic             out_wr_en,
  output logic [REG_W-1:0] out_fpm,
  output logic             fault
);
  assign can_take = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_wr_en <= 1'b0;
      out_fpm   <= '0;
      fault     <= 1'b0;
    end else begin
      fault <= take & fault_d;
      if (take) begin
        out_valid <= 1'b1;
        out_wr_en <= wr_d;
        out_fpm   <= data_d;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  // R11
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_fpm) && $stable(out_wr_en)));

  // R7
  fault_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (out_valid && !out_wr_en));
endmodule

// File: rtl/fpm_ctrl.sv
module fpm_ctrl
  import fpm_pkg::*;
#(
  parameter int REG_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_feat_en,
  input  logic [REG_W-1:0]  in_fpm,
  input  logic [FLAG_W-1:0] in_flags,
  input  logic [ERR_W-1:0]  in_errs,
  output logic              ctl_active,
  output logic [RND_W-1:0]  ctl_round,
  output logic              ctl_exc_suppress,
  output logic              ctl_zeroing,
  output logic              out_valid,
  input  logic              out_ready,
  output logic              out_wr_en,
  output logic [REG_W-1:0]  out_fpm,
  output logic              ill_fault
);
  op_ctl_t          ctl;
  logic             rsv_bad;
  logic             wb_allow;
  logic [REG_W-1:0] merged;
  logic [REG_W-1:0] next_val;
  logic             take;

  fpm_decode #(.REG_W(REG_W)) u_dec (
    .feat_en (in_feat_en),
    .fpm     (in_fpm),
    .ctl     (ctl),
    .rsv_bad (rsv_bad),
    .wb_allow(wb_allow)
  );

  fpm_merge #(.REG_W(REG_W)) u_mrg (
    .fpm   (in_fpm),
    .flags (in_flags),
    .errs  (in_errs),
    .merged(merged)
  );

  assign next_val = wb_allow ? merged : in_fpm;
  assign take     = in_valid && in_ready;

  fpm_outstage #(.REG_W(REG_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .take     (take),
    .wr_d     (wb_allow),
    .data_d   (next_val),
    .fault_d  (rsv_bad),
    .out_ready(out_ready),
    .can_take (in_ready),
    .out_valid(out_valid),
    .out_wr_en(out_wr_en),
    .out_fpm  (out_fpm),
    .fault    (ill_fault)
  );

  assign ctl_active       = ctl.active;
  assign ctl_round        = ctl.rnd;
  assign ctl_exc_suppress = ctl.exc_off;
  assign ctl_zeroing      = ctl.zeroing;

  // R4
  feat_off_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_feat_en) |=> (out_valid && !out_wr_en && out_fpm == $past(in_fpm)));

  // R9
  masked_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && in_feat_en && !in_fpm[PRED_POS]) |=> (!out_wr_en && out_fpm == $past(in_fpm)));

  // R6
  sticky_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> ((out_fpm[ERR_LO +: ERR_W] & $past(in_fpm[ERR_LO +: ERR_W]))
              == $past(in_fpm[ERR_LO +: ERR_W])));

  // R10
  beat_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid);

  // R8
  no_fault_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !in_feat_en) |=> !ill_fault);
endmodule

// File: tb/fpm_ctrl_bench.sv
`timescale 1ns/1ps
module fpm_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_feat_en = 1'b0;
  logic [15:0] in_fpm = '0;
  logic [3:0]  in_flags = '0;
  logic [3:0]  in_errs = '0;
  logic        ctl_active;
  logic [1:0]  ctl_round;
  logic        ctl_exc_suppress;
  logic        ctl_zeroing;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic        out_wr_en;
  logic [15:0] out_fpm;
  logic        ill_fault;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  fpm_ctrl u_fpm_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_feat_en(in_feat_en), .in_fpm(in_fpm), .in_flags(in_flags), .in_errs(in_errs),
    .ctl_active(ctl_active), .ctl_round(ctl_round), .ctl_exc_suppress(ctl_exc_suppress),
    .ctl_zeroing(ctl_zeroing), .out_valid(out_valid), .out_ready(out_ready),
    .out_wr_en(out_wr_en), .out_fpm(out_fpm), .ill_fault(ill_fault)
  );

  // Vector layout: [47] feat, [46:31] fpm, [30:27] flags, [26:23] errs,
  // [22] wr, [21:6] expected fpm, [5] fault, [4:3] round, [2] exc, [1] zero, [0] active
  localparam logic [47:0] TBL [8] = '{
    {1'b0, 16'h001F, 4'hF, 4'hF, 1'b0, 16'h001F, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1}, // R1 R4
    {1'b1, 16'h001F, 4'hA, 4'h1, 1'b1, 16'h035F, 1'b0, 2'd3, 1'b1, 1'b1, 1'b1}, // R2 R5
    {1'b1, 16'h09E5, 4'h0, 4'h2, 1'b1, 16'h0C05, 1'b0, 2'd2, 1'b0, 1'b0, 1'b1}, // R5 R6
    {1'b1, 16'h0208, 4'hF, 4'hF, 1'b0, 16'h0208, 1'b0, 2'd0, 1'b1, 1'b0, 1'b0}, // R9 R3
    {1'b1, 16'h2001, 4'h5, 4'h3, 1'b0, 16'h2001, 1'b1, 2'd0, 1'b0, 1'b0, 1'b1}, // R7
    {1'b0, 16'hE01F, 4'h5, 4'h3, 1'b0, 16'hE01F, 1'b0, 2'd0, 1'b0, 1'b0, 1'b1}, // R8 R7 pulse end
    {1'b1, 16'h1013, 4'h5, 4'h0, 1'b1, 16'h10B3, 1'b0, 2'd1, 1'b0, 1'b1, 1'b1}, // R5 R6
    {1'b0, 16'h0000, 4'h0, 4'h0, 1'b0, 16'h0000, 1'b0, 2'd0, 1'b0, 1'b0, 1'b0}  // R3 R4
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk("R12 out_valid", 32'(out_valid), 32'd0);
    chk("R12 ill_fault", 32'(ill_fault), 32'd0);
    chk("R12 in_ready", 32'(in_ready), 32'd1);

    for (int i = 0; i < 8; i++) begin
      in_valid   = 1'b1;
      in_feat_en = TBL[i][47];
      in_fpm     = TBL[i][46:31];
      in_flags   = TBL[i][30:27];
      in_errs    = TBL[i][26:23];
      #1;
      chk("R1/R2 ctl_round", 32'(ctl_round), 32'(TBL[i][4:3]));
      chk("R1/R2 ctl_exc_suppress", 32'(ctl_exc_suppress), 32'(TBL[i][2]));
      chk("R1/R2 ctl_zeroing", 32'(ctl_zeroing), 32'(TBL[i][1]));
      chk("R3 ctl_active", 32'(ctl_active), 32'(TBL[i][0]));
      @(posedge clk);
      @(negedge clk);
      chk("R10 out_valid", 32'(out_valid), 32'd1);
      chk("R4/R5/R9 out_wr_en", 32'(out_wr_en), 32'(TBL[i][22]));
      chk("R4/R5/R6 out_fpm", 32'(out_fpm), 32'(TBL[i][21:6]));
      chk("R7/R8 ill_fault", 32'(ill_fault), 32'(TBL[i][5]));
    end

    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 idle drop", 32'(out_valid), 32'd0);
    chk("R7 pulse gone", 32'(ill_fault), 32'd0);

    // Back-pressure: op A with full sticky errors
    out_ready  = 1'b0;
    in_valid   = 1'b1;
    in_feat_en = 1'b1;
    in_fpm     = 16'h1E01;
    in_flags   = 4'h3;
    in_errs    = 4'h0;
    @(posedge clk);
    @(negedge clk);
    chk("R6 sticky kept", 32'(out_fpm), 32'h1E61);
    chk("R11 in_ready low", 32'(in_ready), 32'd0);
    // op B waits
    in_fpm   = 16'h0001;
    in_flags = 4'h0;
    in_errs  = 4'h0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk("R11 held valid", 32'(out_valid), 32'd1);
    chk("R11 held data", 32'(out_fpm), 32'h1E61);
    chk("R11 held wr", 32'(out_wr_en), 32'd1);
    out_ready = 1'b1;
    #1;
    chk("R11 in_ready back", 32'(in_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R10 next beat", 32'(out_fpm), 32'h0001);
    chk("R10 next valid", 32'(out_valid), 32'd1);
    in_valid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk("R10 drained", 32'(out_valid), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule